// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single DMA channel. Software fills in a source address, a destination address, a byte count and a control word through a simple register write port. Once started, the channel asks for the bus. After the grant it moves data as single beats on a generic bus master interface. Each transfer either reads at the source and then writes at the destination (dual-address mode), or issues one beat at the source address alone (single-address mode). After each transfer it steps the addresses by their own transfer sizes and lowers the remaining byte count. When the count runs out it raises a done flag and lets go of the bus.

A start comes from a software start bit or from an external request line, as the control word selects. The external path adds a fixed pipeline delay before the channel asks for the bus. Writing the done bit in the status register aborts a running channel and clears the status. Arbitration between channels, alignment fix-up and throttling are handled elsewhere.

Register selects (`wr_sel`): 0 source address, 1 destination address, 2 byte count, 3 control, 4 status. Control word bits: [0] start, [1] external enable, [2] source increment, [3] destination increment, [5:4] source size, [7:6] destination size, [8] single-address mode. Size codes: 0 byte (1), 1 word (2), 2 longword (4), 3 line (16). Status write: bit 0 set means stop and clear.

Top module: `dma_xfer_chan`

## Requirements
- R1: A size code of 0, 1, 2 or 3 moves 1, 2, 4 or 16 bytes. After each transfer, an address with its increment bit set advances by the byte count of its own size code.
- R2: An address whose increment bit is clear keeps its value across transfers.
- R3: After each transfer the byte count drops by the destination size (dual mode) or the source size (single mode). A count smaller than the step becomes zero instead of wrapping.
- R4: When a transfer leaves the count at zero, `done` rises and `busy` and `bus_req` fall in the same cycle. The count stays at zero. Out of reset, `busy`, `done`, `bus_req`, `m_valid` and the count are all zero.
- R5: With external enable clear, a control write with the start bit set raises `busy` and `bus_req` in the next cycle.
- R6: With external enable set, the idle channel does not start until `ext_req` is sampled high. `ext_req` has no effect while external enable is clear.
- R7: From the clock edge that samples `ext_req` high, at least 4 cycles pass before `m_valid` first rises.
- R8: In dual mode each transfer is a read beat at the source address with the source size, followed by a write beat at the destination address with the destination size.
- R9: In single mode each transfer is one read beat at the source address. The destination address is never stepped.
- R10: No beat is issued before `bus_gnt`. A beat completes only on `m_ready`. Addresses and count change only when a transfer's final beat completes.
- R11: A status write with bit 0 set drops `busy`, `bus_req` and `m_valid` in the next cycle and clears `done`. The count and addresses keep the values they had at the stop.
- R12: A start is ignored while `done` is set, while the count is zero, or while the channel is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | DW | Register write data |
| ext_req | input | 1 | External transfer request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| m_valid | output | 1 | Beat address phase valid |
| m_write | output | 1 | Beat is a write |
| m_addr | output | AW | Beat address |
| m_size | output | 2 | Beat size code |
| m_ready | input | 1 | Beat acknowledge |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| byte_cnt | output | CW | Remaining byte count |
| busy | output | 1 | Channel active |
| done | output | 1 | Transfer block completed |

## Verification
Random dual- and single-mode runs draw all sixteen size pairs together with every increment setting. This separates a wrong step per size code from a wrong choice of which side's size drives the count. A count that is not a multiple of the step shows whether the count saturates or wraps. A held grant, slow ready and a mid-run start write show that nothing moves without a handshake and that a busy channel cannot be restarted. External-request runs, with and without the enable, measure the start latency and show that the line is gated. An abort partway through a long block shows that the channel stops at once and keeps its partial state.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LINE = 2'd3
  } xsize_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_ARB  = 3'd2,
    ST_RD   = 3'd3,
    ST_WR   = 3'd4
  } seq_st_e;

  // control word bits [8:1]; bit 0 is the start strobe and is not stored
  typedef struct packed {
    logic   single;
    xsize_e dsz;
    xsize_e ssz;
    logic   dinc;
    logic   sinc;
    logic   ext_en;
  } ctl_t;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTL  = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  function automatic logic [4:0] size_bytes(input xsize_e s);
    case (s)
      SZ_BYTE: size_bytes = 5'd1;
      SZ_WORD: size_bytes = 5'd2;
      SZ_LONG: size_bytes = 5'd4;
      default: size_bytes = 5'd16;
    endcase
  endfunction

  // remaining count after one transfer, saturating at zero
  function automatic logic [31:0] cnt_next(input logic [31:0] c, input logic [4:0] step);
    if (c > {27'd0, step}) cnt_next = c - {27'd0, step};
    else                   cnt_next = 32'd0;
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
`timescale 1ns/1ps
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          adv,
  input  logic          inc_en,
  input  xsize_e        sz,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] stride;

  always_comb stride = AW'(size_bytes(sz));

  always_ff @(posedge clk) begin
    if (!rst_n)             addr <= '0;
    else if (load)          addr <= load_val[AW-1:0];
    else if (adv && inc_en) addr <= addr + stride;
  end

endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          xfer_done,
  input  logic          abort,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output ctl_t          ctl_q,
  output logic          done_q,
  output logic          last_xfer,
  output logic          cnt_nz
);

  localparam int NSIDE = 2;

  logic [4:0]           step;
  logic [CW-1:0]        cnt_after;
  logic [NSIDE-1:0][AW-1:0] addr_v;

  always_comb begin
    step      = ctl_q.single ? size_bytes(ctl_q.ssz) : size_bytes(ctl_q.dsz);
    cnt_after = CW'(cnt_next(32'(cnt_q), step));
    last_xfer = (cnt_after == '0);
    cnt_nz    = (cnt_q != '0);
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    logic   ld, adv, inc;
    xsize_e sz;
    always_comb begin
      ld  = wr_en && (wr_sel == ((g == 0) ? SEL_SRC : SEL_DST));
      inc = (g == 0) ? ctl_q.sinc : ctl_q.dinc;
      sz  = (g == 0) ? ctl_q.ssz : ctl_q.dsz;
      adv = xfer_done && ((g == 0) || !ctl_q.single);
    end
    dma_addr_step #(.AW(AW), .DW(DW)) u_step (
      .clk(clk), .rst_n(rst_n), .load(ld), .load_val(wr_data),
      .adv(adv), .inc_en(inc), .sz(sz), .addr(addr_v[g])
    );
  end

  assign src_q = addr_v[0];
  assign dst_q = addr_v[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ctl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_CNT) cnt_q <= wr_data[CW-1:0];
      else if (xfer_done)             cnt_q <= cnt_after;

      if (wr_en && wr_sel == SEL_CTL) ctl_q <= ctl_t'(wr_data[8:1]);

      if (abort)                          done_q <= 1'b0;
      else if (xfer_done && last_xfer)    done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int EXT_DLY = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_sw,
  input  logic    ext_en,
  input  logic    ext_req,
  input  logic    armed,
  input  logic    abort,
  input  logic    single,
  input  logic    last_xfer,
  input  logic    bus_gnt,
  input  logic    m_ready,
  output seq_st_e st_q,
  output logic    xfer_done,
  output logic    start_ext,
  output logic    busy,
  output logic    bus_req,
  output logic    m_valid,
  output logic    m_write
);

  localparam int DCW = (EXT_DLY < 2) ? 1 : $clog2(EXT_DLY);

  seq_st_e        st_d;
  logic [DCW-1:0] dcnt_q;
  logic           idle, go_sw, beat_ack;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    go_sw     = idle && start_sw && armed && !abort;
    start_ext = idle && !go_sw && ext_en && ext_req && armed && !abort;
    busy      = !idle;
    bus_req   = (st_q == ST_ARB) || (st_q == ST_RD) || (st_q == ST_WR);
    m_valid   = (st_q == ST_RD) || (st_q == ST_WR);
    m_write   = (st_q == ST_WR);
    beat_ack  = m_valid && m_ready;
    xfer_done = beat_ack && !abort &&
                ((st_q == ST_WR) || ((st_q == ST_RD) && single));
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go_sw) st_d = ST_ARB;
               else if (start_ext) st_d = ST_HOLD;
      ST_HOLD: if (dcnt_q == DCW'(EXT_DLY - 1)) st_d = ST_ARB;
      ST_ARB:  if (bus_gnt) st_d = ST_RD;
      ST_RD:   if (m_ready) st_d = single ? (last_xfer ? ST_IDLE : ST_RD) : ST_WR;
      ST_WR:   if (m_ready) st_d = last_xfer ? ST_IDLE : ST_RD;
      default: st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= (st_q == ST_HOLD) ? dcnt_q + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/dma_xfer_chan.sv
`timescale 1ns/1ps
module dma_xfer_chan
  import dma_chan_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 24,
  parameter int DW      = 32,
  parameter int EXT_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ext_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          m_valid,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  input  logic          m_ready,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] byte_cnt,
  output logic          busy,
  output logic          done
);

  ctl_t    ctl_q;
  seq_st_e st_q;
  logic    start_sw, abort_w, armed, last_xfer, cnt_nz;
  logic    xfer_done, start_ext;

  // named events used by the checker
  always_comb begin
    start_sw = wr_en && (wr_sel == SEL_CTL) && wr_data[0] && !wr_data[1];
    abort_w  = wr_en && (wr_sel == SEL_STAT) && wr_data[0];
    armed    = !done && cnt_nz;
  end

  dma_chan_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_done(xfer_done), .abort(abort_w),
    .src_q(src_addr), .dst_q(dst_addr), .cnt_q(byte_cnt), .ctl_q(ctl_q),
    .done_q(done), .last_xfer(last_xfer), .cnt_nz(cnt_nz)
  );

  dma_chan_seq #(.EXT_DLY(EXT_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_sw(start_sw), .ext_en(ctl_q.ext_en),
    .ext_req(ext_req), .armed(armed), .abort(abort_w), .single(ctl_q.single),
    .last_xfer(last_xfer), .bus_gnt(bus_gnt), .m_ready(m_ready), .st_q(st_q),
    .xfer_done(xfer_done), .start_ext(start_ext), .busy(busy), .bus_req(bus_req),
    .m_valid(m_valid), .m_write(m_write)
  );

  always_comb begin
    m_addr = m_write ? dst_addr : src_addr;
    m_size = m_write ? ctl_q.dsz : ctl_q.ssz;
  end

endmodule

// File: rtl/dma_xfer_chan_chk.sv
`timescale 1ns/1ps
module dma_xfer_chan_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          m_valid,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] byte_cnt,
  input logic          xfer_done,
  input logic          start_ext,
  input logic          abort_w,
  input logic          sinc,
  input logic          single
);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !m_valid));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done && !(wr_en && wr_sel == 3'd2)) |=> $stable(byte_cnt));

  // R2
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !sinc && !(wr_en && wr_sel == 3'd0)) |=> $stable(src_addr));

  // R9
  dst_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && single && !(wr_en && wr_sel == 3'd1)) |=> $stable(dst_addr));

  // R7
  ext_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ext |=> !m_valid ##1 !m_valid ##1 !m_valid ##1 !m_valid);

  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!busy && !bus_req && !done));

endmodule

bind dma_xfer_chan dma_xfer_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .busy(busy),
  .done(done), .bus_req(bus_req), .m_valid(m_valid), .src_addr(src_addr),
  .dst_addr(dst_addr), .byte_cnt(byte_cnt), .xfer_done(xfer_done),
  .start_ext(start_ext), .abort_w(abort_w), .sinc(ctl_q.sinc),
  .single(ctl_q.single)
);

// File: tb/sim_dma_xfer_chan.sv
`timescale 1ns/1ps
module sim_dma_xfer_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        ext_req = 1'b0;
  logic        bus_req, bus_gnt, m_valid, m_write, m_ready;
  logic [31:0] m_addr, src_addr, dst_addr;
  logic [1:0]  m_size;
  logic [23:0] byte_cnt;
  logic        busy, done;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  bit gnt_fast = 0, rdy_fast = 0, gnt_block = 0;
  int rec_n = 0;
  logic [31:0] rec_addr [256];
  logic        rec_wr   [256];
  logic [1:0]  rec_sz   [256];

  always #10 clk = ~clk;  // 50 MHz

  dma_xfer_chan u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_req(ext_req), .bus_req(bus_req), .bus_gnt(bus_gnt), .m_valid(m_valid),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_ready(m_ready),
    .src_addr(src_addr), .dst_addr(dst_addr), .byte_cnt(byte_cnt),
    .busy(busy), .done(done)
  );

  // bus responder: decisions made at the falling edge, taken at the next rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 1'b0;
      m_ready = 1'b0;
    end else begin
      bus_gnt = bus_req && !gnt_block && (gnt_fast || ($urandom % 2 == 0));
      m_ready = m_valid && (rdy_fast || ($urandom % 3 != 0));
      if (m_valid && m_ready && rec_n < 256) begin
        rec_addr[rec_n] = m_addr;
        rec_wr[rec_n]   = m_write;
        rec_sz[rec_n]   = m_size;
        rec_n++;
      end
    end
  end

  function automatic int nbytes(input int code);
    return (code == 3) ? 16 : (1 << code);
  endfunction

  function automatic logic [31:0] mk_ctl(input int st, ext, si, di, ss, ds, sg);
    return 32'(st | (ext << 1) | (si << 2) | (di << 3) | (ss << 4) | (ds << 6) | (sg << 8));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    int n = 0;
    while (busy && n < maxc) begin
      @(negedge clk);
      n++;
    end
    if (busy) chk(0, "R4 completion timeout", 1, 0);
  endtask

  task automatic run_xfer(input int ss, ds, si, di, sg, cnt,
                          input logic [31:0] s0, d0, input bit restart);
    int step, ntr, nb, bad;
    logic [31:0] es, ed;
    step = sg ? nbytes(ss) : nbytes(ds);
    ntr  = (cnt + step - 1) / step;
    reg_wr(3'd4, 32'd1);
    reg_wr(3'd0, s0);
    reg_wr(3'd1, d0);
    reg_wr(3'd2, 32'(cnt));
    rec_n = 0;
    reg_wr(3'd3, mk_ctl(1, 0, si, di, ss, ds, sg));
    if (restart) begin
      repeat (2) @(negedge clk);
      reg_wr(3'd3, mk_ctl(1, 0, si, di, ss, ds, sg));  // R12 start while busy
    end
    wait_idle(5000);
    nb = sg ? ntr : 2 * ntr;
    chk(rec_n == nb, sg ? "R9 beat count" : "R8 beat count", rec_n, nb);
    bad = 0;
    for (int i = 0; i < ntr && i < 128; i++) begin
      es = s0 + 32'(i * nbytes(ss) * si);
      ed = d0 + 32'(i * nbytes(ds) * di);
      if (sg) begin
        if (rec_addr[i] != es || rec_wr[i] || rec_sz[i] != 2'(ss)) bad++;
      end else begin
        if (rec_addr[2*i] != es || rec_wr[2*i] || rec_sz[2*i] != 2'(ss)) bad++;
        if (rec_addr[2*i+1] != ed || !rec_wr[2*i+1] || rec_sz[2*i+1] != 2'(ds)) bad++;
      end
    end
    chk(bad == 0, sg ? "R9 beat sequence" : "R8 beat sequence", bad, 0);
    es = s0 + 32'(ntr * nbytes(ss) * si);
    ed = sg ? d0 : d0 + 32'(ntr * nbytes(ds) * di);
    chk(src_addr == es, si ? "R1 source step" : "R2 source hold", src_addr, es);
    chk(dst_addr == ed, sg ? "R9 destination unused" : (di ? "R1 dest step" : "R2 dest hold"),
        dst_addr, ed);
    chk(byte_cnt == 0, "R3 count to zero", byte_cnt, 0);
    chk(done && !busy && !bus_req, "R4 done and released", {done, busy, bus_req}, 3'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_sim();
  end

  initial begin
    int seed, k, sg, ss, ds, step;
    logic [23:0] c1;
    logic [31:0] a1;
    seed = $urandom(32'd7731);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk(!busy && !done && !bus_req && !m_valid && byte_cnt == 0, "R4 reset state",
        {busy, done, bus_req, m_valid}, 0);

    // R3 count not a multiple of the step saturates at zero
    run_xfer(0, 1, 1, 1, 0, 5, 32'h1000, 32'h2000, 0);
    // R1 line size in single mode
    run_xfer(3, 0, 1, 1, 1, 48, 32'h4000, 32'h8000, 0);

    // R12 start ignored while done is set
    reg_wr(3'd3, mk_ctl(1, 0, 1, 1, 0, 0, 0));
    @(negedge clk);
    chk(!busy && !bus_req, "R12 start with done set", busy, 0);
    // R12 start ignored with zero count
    reg_wr(3'd4, 32'd1);
    reg_wr(3'd2, 32'd0);
    reg_wr(3'd3, mk_ctl(1, 0, 1, 1, 0, 0, 0));
    @(negedge clk);
    chk(!busy && !bus_req, "R12 start with zero count", busy, 0);

    // random runs
    for (int r = 0; r < 18; r++) begin
      ss = int'($urandom % 4); ds = int'($urandom % 4); sg = int'($urandom % 2);
      step = sg ? nbytes(ss) : nbytes(ds);
      k = 1 + int'($urandom % 6);
      gnt_fast = ($urandom % 2) == 1;
      rdy_fast = ($urandom % 2) == 1;
      run_xfer(ss, ds, int'($urandom % 2), int'($urandom % 2), sg, k * step,
               $urandom, $urandom, 0);
    end

    // R12 restart attempt while busy
    gnt_fast = 0; rdy_fast = 0;
    run_xfer(2, 2, 1, 1, 0, 40, 32'h100, 32'h900, 1);

    // R10 no beat without grant, R5 immediate request
    gnt_block = 1;
    reg_wr(3'd4, 32'd1);
    reg_wr(3'd2, 32'd4);
    reg_wr(3'd3, mk_ctl(1, 0, 1, 1, 0, 0, 0));
    chk(busy && bus_req, "R5 request after start", {busy, bus_req}, 2'b11);
    repeat (5) @(negedge clk);
    chk(bus_req && !m_valid && byte_cnt == 4, "R10 held without grant",
        {bus_req, m_valid, byte_cnt}, {2'b10, 24'd4});
    gnt_block = 0;
    wait_idle(500);
    chk(byte_cnt == 0 && done, "R10 completes after grant", byte_cnt, 0);

    // R6 external enable: waits for the request line
    gnt_fast = 1; rdy_fast = 1;
    reg_wr(3'd4, 32'd1);
    reg_wr(3'd2, 32'd4);
    reg_wr(3'd3, mk_ctl(0, 1, 1, 1, 2, 2, 0));
    repeat (6) @(negedge clk);
    chk(!busy && !bus_req, "R6 waits for request", busy, 0);
    ext_req = 1'b1;
    @(negedge clk);
    ext_req = 1'b0;
    k = 1;
    while (!m_valid && k < 50) begin
      @(negedge clk);
      k++;
    end
    chk(k >= 5, "R7 request-to-beat latency", k - 1, 4);
    wait_idle(500);
    chk(done && byte_cnt == 0, "R6 external run completes", byte_cnt, 0);

    // R6 request line ignored with external enable clear
    reg_wr(3'd4, 32'd1);
    reg_wr(3'd2, 32'd8);
    reg_wr(3'd3, mk_ctl(0, 0, 1, 1, 0, 0, 0));
    ext_req = 1'b1;
    repeat (2) @(negedge clk);
    ext_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy && !bus_req && byte_cnt == 8, "R6 request ignored when disabled", busy, 0);

    // R11 abort mid-block
    gnt_fast = 1; rdy_fast = 0;
    reg_wr(3'd4, 32'd1);
    reg_wr(3'd0, 32'h3000);
    reg_wr(3'd2, 32'd64);
    reg_wr(3'd3, mk_ctl(1, 0, 1, 1, 0, 0, 0));
    repeat (6) @(negedge clk);
    reg_wr(3'd4, 32'd1);
    chk(!busy && !bus_req && !m_valid && !done, "R11 stop on status write",
        {busy, bus_req, m_valid, done}, 0);
    c1 = byte_cnt; a1 = src_addr;
    chk(c1 != 0 && c1 < 64, "R11 partial count kept", c1, 1);
    repeat (5) @(negedge clk);
    chk(byte_cnt == c1 && src_addr == a1, "R11 state frozen after stop", byte_cnt, c1);

    finish_sim();
  end

endmodule